// File: doc/BRIEF.md
# Power-Down Entry and Exit Sequencer

This block decides, cycle by cycle, which output groups of a multi-output clock generator are held stopped while the part goes into and comes out of its low-power state. An active-low power-down pin is filtered on the sequencer clock. When it is seen low, the groups are stopped one step per cycle in a fixed order: the PCI outputs, then the three buffered 66 MHz outputs, then the CPU pairs together with the internally generated 66 MHz outputs, then the 48 MHz outputs, and last the reference output. The oscillator and the PLLs are switched off only after the reference gate reports that it has really stopped.

On exit the oscillator and PLLs are turned back on and every output stays stopped until the PLL reports lock. At lock the CPU pairs, the internal 66 MHz outputs and buffered output 1 run together. Buffered output 1 is the feedback path that a downstream DLL needs first. After a programmable delay counted in sequencer cycles, buffered outputs 0 and 2 start. The PCI outputs follow on the next cycle, and the 48 MHz and reference outputs on the cycle after that. Per-output gate cells, the PLL and the lock detector sit outside this block and use its stop and enable signals.

Top module: `pd_sequencer`

## Requirements
- R1: After reset all stop outputs are 0, `osc_en` and `pll_en` are 1 and `cpu_bias2x` is 0.
- R2: Power-down starts only when `pd_n` is sampled low on two consecutive rising edges. `stop_pci` rises on the third rising edge after the first low sample. A low pulse of one cycle changes no output.
- R3: Entry asserts stops on successive cycles: PCI, then both buffered groups, then core, then 48 MHz, then reference. The sequence then holds until `ref_stop_ack` is sampled high. On the following edge `osc_en` and `pll_en` fall.
- R4: If `pci_stop_n` is low on the edge that starts entry, `stop_pci_free` rises together with `stop_pci`. Otherwise it rises together with `stop_core`.
- R5: `cpu_bias2x` is 1 exactly while the core group is stopped, that is, from the core stop step until the core release.
- R6: In the off state, `osc_en` and `pll_en` rise on the third edge after `pd_n` is first sampled high. All stops stay asserted as long as `pll_lock` is low.
- R7: On the edge after `pll_lock` is sampled high, `stop_core` and `stop_buf1` fall together. All other stops stay asserted.
- R8: `stop_buf02` falls exactly REL_DLY cycles after `stop_core` falls. `stop_pci` and `stop_pci_free` fall one cycle later, and `stop_48m` and `stop_ref` fall one cycle after that.
- R9: A return of `pd_n` to high during entry does not cut entry short. Entry finishes, the off state lasts one cycle, and the complete exit sequence then runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| rst_n | input | 1 | Synchronous reset, active low |
| pd_n | input | 1 | Power-down request pin, active low |
| pci_stop_n | input | 1 | PCI stop pin, active low; selects the early stop of the free-running PCI outputs |
| pll_lock | input | 1 | Lock indication from the PLL lock detector |
| ref_stop_ack | input | 1 | Reference gate reports its output is held low |
| stop_pci | output | 1 | Stop for the stoppable PCI outputs |
| stop_pci_free | output | 1 | Stop for the free-running PCI outputs |
| stop_buf1 | output | 1 | Stop for buffered 66 MHz output 1 (feedback) |
| stop_buf02 | output | 1 | Stop for buffered 66 MHz outputs 0 and 2 |
| stop_core | output | 1 | Stop for CPU pairs and internal 66 MHz outputs |
| stop_48m | output | 1 | Stop for the 48 MHz outputs |
| stop_ref | output | 1 | Stop for the reference output |
| osc_en | output | 1 | Oscillator enable |
| pll_en | output | 1 | PLL enable |
| cpu_bias2x | output | 1 | CPU true outputs held high at twice reference current, complement undriven |

## Verification
The bench builds the block with REL_DLY set to 12 in place of the default of about 1430 cycles. This lets many full entry and exit cycles fit in a short run and makes it cheap to check, down to the exact edge, that the staged release delay ends where it should. The random cycles vary the PCI stop pin, the reference acknowledge latency, the lock latency and the time spent off. Directed cases cover the one-cycle glitch on the request pin and a release that arrives in the middle of entry.

// File: rtl/pdseq_pkg.sv
// Package: shared state encoding and stop-vector type for the power-down sequencer.
package pdseq_pkg;

    // Sequencer phases: entry steps, the off state, and exit steps.
    typedef enum logic [3:0] {
        ST_RUN    = 4'd0,
        ST_E_PCI  = 4'd1,
        ST_E_BUF  = 4'd2,
        ST_E_CORE = 4'd3,
        ST_E_48   = 4'd4,
        ST_E_REF  = 4'd5,
        ST_OFF    = 4'd6,
        ST_X_LOCK = 4'd7,
        ST_X_DLY  = 4'd8,
        ST_X_BUF  = 4'd9,
        ST_X_PCI  = 4'd10
    } seq_state_e;

    // One stop request per output group.
    typedef struct packed {
        logic pci;
        logic pci_free;
        logic buf1;
        logic buf02;
        logic core;
        logic c48;
        logic refclk;
    } stop_vec_t;

endpackage

// File: rtl/pdseq_filter.sv
// Module: pdseq_filter
// Shifts the raw power-down pin through NSAMP flops. It reports "low seen"
// when every sample is low and "high seen" when every sample is high.
// Assumes the pin is already synchronous to clk, or that it is only
// sampled as a level. Reset fills the history with ones (not powered down).
module pdseq_filter #(
    parameter int NSAMP = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_n,
    output logic low_seen,
    output logic high_seen
);

    logic [NSAMP-1:0] hist;

    // Shift in one sample of the pin per clock.
    always_ff @(posedge clk) begin
        if (!rst_n) hist <= '1;
        else        hist <= {hist[NSAMP-2:0], pin_n};
    end

    // Qualified levels: all samples agree.
    always_comb begin
        low_seen  = ~|hist;
        high_seen = &hist;
    end

endmodule

// File: rtl/pdseq_timer.sv
// Module: pdseq_timer
// Counts the cycles during which run is high and clears when run is low.
// done is high in the DLY-th consecutive run cycle. Assumes DLY >= 2.
module pdseq_timer #(
    parameter int DLY = 1432
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic done
);

    localparam int W = $clog2(DLY + 1);
    localparam logic [W-1:0] LAST = W'(DLY - 1);

    logic [W-1:0] cnt;

    // Advance while running, otherwise hold at zero.
    always_ff @(posedge clk) begin
        if (!rst_n)     cnt <= '0;
        else if (!run)  cnt <= '0;
        else if (!done) cnt <= cnt + 1'b1;
    end

    // Terminal count flag.
    assign done = run && (cnt == LAST);

endmodule

// File: rtl/pdseq_decode.sv
// Module: pdseq_decode
// Maps the sequencer phase to the group stops and the oscillator/PLL
// enables. Purely combinational. pci_early picks whether the free-running
// PCI group stops in the PCI step or in the core step.
module pdseq_decode
    import pdseq_pkg::*;
(
    input  seq_state_e state,
    input  logic       pci_early,
    output stop_vec_t  stops,
    output logic       osc_en,
    output logic       pll_en,
    output logic       cpu_bias2x
);

    // Per-phase stop set and enables.
    always_comb begin
        stops      = '0;
        osc_en     = 1'b1;
        pll_en     = 1'b1;
        cpu_bias2x = 1'b0;
        unique case (state)
            ST_RUN: ;
            ST_E_PCI: begin
                stops.pci      = 1'b1;
                stops.pci_free = pci_early;
            end
            ST_E_BUF: begin
                stops.pci      = 1'b1;
                stops.pci_free = pci_early;
                stops.buf1     = 1'b1;
                stops.buf02    = 1'b1;
            end
            ST_E_CORE: begin
                stops      = '{pci:1'b1, pci_free:1'b1, buf1:1'b1, buf02:1'b1,
                               core:1'b1, c48:1'b0, refclk:1'b0};
                cpu_bias2x = 1'b1;
            end
            ST_E_48: begin
                stops        = '1;
                stops.refclk = 1'b0;
                cpu_bias2x   = 1'b1;
            end
            ST_E_REF, ST_X_LOCK: begin
                stops      = '1;
                cpu_bias2x = 1'b1;
            end
            ST_OFF: begin
                stops      = '1;
                osc_en     = 1'b0;
                pll_en     = 1'b0;
                cpu_bias2x = 1'b1;
            end
            ST_X_DLY: begin
                stops      = '1;
                stops.core = 1'b0;
                stops.buf1 = 1'b0;
            end
            ST_X_BUF: begin
                stops.pci      = 1'b1;
                stops.pci_free = 1'b1;
                stops.c48      = 1'b1;
                stops.refclk   = 1'b1;
            end
            ST_X_PCI: begin
                stops.c48    = 1'b1;
                stops.refclk = 1'b1;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/pd_sequencer.sv
// Module: pd_sequencer (top)
// Sequences a clock generator into and out of power-down. Entry takes one
// group step per cycle and waits for the reference gate's acknowledge
// before it turns off the oscillator and PLLs. Exit waits for PLL lock,
// releases the core group and the feedback buffer, waits REL_DLY cycles,
// then releases the remaining groups in order. A release request that
// arrives during entry is only acted on from the off state.
module pd_sequencer
    import pdseq_pkg::*;
#(
    parameter int REL_DLY = 1432,
    parameter int FILT_N  = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pd_n,
    input  logic pci_stop_n,
    input  logic pll_lock,
    input  logic ref_stop_ack,
    output logic stop_pci,
    output logic stop_pci_free,
    output logic stop_buf1,
    output logic stop_buf02,
    output logic stop_core,
    output logic stop_48m,
    output logic stop_ref,
    output logic osc_en,
    output logic pll_en,
    output logic cpu_bias2x
);

    seq_state_e state, state_nx;
    logic       pd_low, pd_high;
    logic       dly_done;
    logic       pci_early;
    stop_vec_t  stops;

    pdseq_filter #(.NSAMP(FILT_N)) u_filt (
        .clk       (clk),
        .rst_n     (rst_n),
        .pin_n     (pd_n),
        .low_seen  (pd_low),
        .high_seen (pd_high)
    );

    pdseq_timer #(.DLY(REL_DLY)) u_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (state == ST_X_DLY),
        .done  (dly_done)
    );

    pdseq_decode u_dec (
        .state      (state),
        .pci_early  (pci_early),
        .stops      (stops),
        .osc_en     (osc_en),
        .pll_en     (pll_en),
        .cpu_bias2x (cpu_bias2x)
    );

    // Next-phase selection.
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_RUN:    if (pd_low) state_nx = ST_E_PCI;
            ST_E_PCI:  state_nx = ST_E_BUF;
            ST_E_BUF:  state_nx = ST_E_CORE;
            ST_E_CORE: state_nx = ST_E_48;
            ST_E_48:   state_nx = ST_E_REF;
            ST_E_REF:  if (ref_stop_ack) state_nx = ST_OFF;
            ST_OFF:    if (pd_high) state_nx = ST_X_LOCK;
            ST_X_LOCK: if (pll_lock) state_nx = ST_X_DLY;
            ST_X_DLY:  if (dly_done) state_nx = ST_X_BUF;
            ST_X_BUF:  state_nx = ST_X_PCI;
            ST_X_PCI:  state_nx = ST_RUN;
            default:   state_nx = ST_RUN;
        endcase
    end

    // Phase register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_RUN;
        else        state <= state_nx;
    end

    // Capture the PCI stop pin at the start of entry.
    always_ff @(posedge clk) begin
        if (!rst_n)                        pci_early <= 1'b0;
        else if (state == ST_RUN && pd_low) pci_early <= ~pci_stop_n;
    end

    assign stop_pci      = stops.pci;
    assign stop_pci_free = stops.pci_free;
    assign stop_buf1     = stops.buf1;
    assign stop_buf02    = stops.buf02;
    assign stop_core     = stops.core;
    assign stop_48m      = stops.c48;
    assign stop_ref      = stops.refclk;

endmodule

// File: rtl/pd_sequencer_chk.sv
// Module: pd_sequencer_chk
// Checker bound to pd_sequencer. It watches only the ports and keeps
// its own cycle counter for the staged release window.
module pd_sequencer_chk #(
    parameter int REL_DLY = 1432
) (
    input logic clk,
    input logic rst_n,
    input logic pd_n,
    input logic pll_lock,
    input logic stop_pci,
    input logic stop_pci_free,
    input logic stop_buf1,
    input logic stop_buf02,
    input logic stop_core,
    input logic stop_48m,
    input logic stop_ref,
    input logic osc_en,
    input logic pll_en,
    input logic cpu_bias2x
);

    int unsigned win_cnt;

    // Counts cycles with the core group running and buffers 0/2 still stopped.
    always_ff @(posedge clk) begin
        if (!rst_n)                     win_cnt <= 0;
        else if (!stop_core && stop_buf02) win_cnt <= win_cnt + 1;
        else                            win_cnt <= 0;
    end

    assert_filter_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stop_pci) |-> (!$past(pd_n, 1) && !$past(pd_n, 2)));

    assert_buf_after_pci_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stop_buf02) |-> $past(stop_pci));

    assert_core_after_buf_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stop_core) |-> $past(stop_buf02));

    assert_48_after_core_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stop_48m) |-> $past(stop_core));

    assert_ref_after_48_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stop_ref) |-> $past(stop_48m));

    assert_osc_off_stopped_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !osc_en |-> (stop_ref && stop_core && !pll_en));

    assert_free_pci_by_core_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stop_core) |-> stop_pci_free);

    assert_bias_with_core_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_bias2x |-> stop_core);

    assert_pll_on_from_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pll_en) |-> $past(stop_ref));

    assert_release_needs_lock_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(stop_core) |-> ($past(pll_lock) && $fell(stop_buf1) && stop_buf02));

    assert_delay_window_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(stop_buf02) |-> (win_cnt == REL_DLY));

    assert_pci_after_buf_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(stop_pci) |-> ($past(!stop_buf02) && stop_48m));

endmodule

bind pd_sequencer pd_sequencer_chk #(.REL_DLY(REL_DLY)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .pd_n          (pd_n),
    .pll_lock      (pll_lock),
    .stop_pci      (stop_pci),
    .stop_pci_free (stop_pci_free),
    .stop_buf1     (stop_buf1),
    .stop_buf02    (stop_buf02),
    .stop_core     (stop_core),
    .stop_48m      (stop_48m),
    .stop_ref      (stop_ref),
    .osc_en        (osc_en),
    .pll_en        (pll_en),
    .cpu_bias2x    (cpu_bias2x)
);

// File: tb/pd_sequencer_tb.sv
// Bench for pd_sequencer: directed corner cases plus seeded random power cycles.
module pd_sequencer_tb;

    localparam int DLY = 12;

    logic clk = 1'b0;
    logic rst_n, pd_n, pci_stop_n, pll_lock, ref_stop_ack;
    logic stop_pci, stop_pci_free, stop_buf1, stop_buf02, stop_core;
    logic stop_48m, stop_ref, osc_en, pll_en, cpu_bias2x;

    int  n_tests = 0;
    int  n_fail  = 0;
    bit  finished = 1'b0;

    always #2 clk = ~clk;

    pd_sequencer #(.REL_DLY(DLY)) u_dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .pd_n          (pd_n),
        .pci_stop_n    (pci_stop_n),
        .pll_lock      (pll_lock),
        .ref_stop_ack  (ref_stop_ack),
        .stop_pci      (stop_pci),
        .stop_pci_free (stop_pci_free),
        .stop_buf1     (stop_buf1),
        .stop_buf02    (stop_buf02),
        .stop_core     (stop_core),
        .stop_48m      (stop_48m),
        .stop_ref      (stop_ref),
        .osc_en        (osc_en),
        .pll_en        (pll_en),
        .cpu_bias2x    (cpu_bias2x)
    );

    // Expected stops {pci, pci_free, buf1, buf02, core, 48m, ref} per phase:
    // 0 run, 1 pci step, 2 buffer step, 3 core step, 4 48m step,
    // 5 all stopped, 6 core released, 7 buffers released, 8 pci released.
    function automatic logic [6:0] exp_stops(input int ph, input bit early);
        case (ph)
            1: return {1'b1, early, 5'b00000};
            2: return {1'b1, early, 5'b11000};
            3: return 7'b1111100;
            4: return 7'b1111110;
            5: return 7'b1111111;
            6: return 7'b1101011;
            7: return 7'b1100011;
            8: return 7'b0000011;
            default: return 7'b0000000;
        endcase
    endfunction

    task automatic tick;
        @(posedge clk);
        #1;
    endtask

    task automatic chk_stops(input string req, input logic [6:0] exp);
        logic [6:0] act;
        act = {stop_pci, stop_pci_free, stop_buf1, stop_buf02, stop_core, stop_48m, stop_ref};
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s stops act=%b exp=%b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic chk_bit(input string req, input string what, input logic act, input logic exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s act=%b exp=%b at %0t", req, what, act, exp, $time);
        end
    endtask

    // One full power-down and wake-up, checked edge by edge.
    task automatic power_cycle(input bit pcisn, input int ack_lat, input int lock_lat,
                               input int idle, input bit mid_rel);
        bit    early;
        string tag;
        early = !pcisn;
        tag   = mid_rel ? "R9" : "R3";
        pci_stop_n = pcisn;
        pd_n = 1'b0;
        tick; tick;
        chk_stops("R2", exp_stops(0, early));
        tick;
        chk_stops("R2", exp_stops(1, early));
        chk_bit("R4", "pci_free", stop_pci_free, early);
        if (mid_rel) pd_n = 1'b1;
        tick; chk_stops(tag, exp_stops(2, early));
        tick; chk_stops(tag, exp_stops(3, early));
        chk_bit("R5", "bias", cpu_bias2x, 1'b1);
        chk_bit("R4", "pci_free", stop_pci_free, 1'b1);
        tick; chk_stops(tag, exp_stops(4, early));
        tick; chk_stops(tag, exp_stops(5, early));
        chk_bit("R3", "osc_en", osc_en, 1'b1);
        for (int i = 0; i < ack_lat; i++) begin
            tick;
            chk_bit("R3", "osc_en wait ack", osc_en, 1'b1);
        end
        ref_stop_ack = 1'b1;
        tick;
        chk_bit(tag, "osc_en off", osc_en, 1'b0);
        chk_bit(tag, "pll_en off", pll_en, 1'b0);
        ref_stop_ack = 1'b0;
        pll_lock = 1'b0;
        if (!mid_rel) begin
            for (int i = 0; i < idle; i++) tick;
            chk_bit("R6", "osc_en idle", osc_en, 1'b0);
            pd_n = 1'b1;
            tick; tick;
            chk_bit("R6", "osc_en early", osc_en, 1'b0);
        end
        tick;
        chk_bit("R6", "pll_en on", pll_en, 1'b1);
        chk_stops("R6", exp_stops(5, early));
        for (int i = 0; i < lock_lat; i++) begin
            tick;
            chk_stops("R6", exp_stops(5, early));
        end
        pll_lock = 1'b1;
        tick;
        chk_stops("R7", exp_stops(6, early));
        chk_bit("R5", "bias off", cpu_bias2x, 1'b0);
        for (int i = 0; i < DLY - 1; i++) tick;
        chk_stops("R8", exp_stops(6, early));
        tick; chk_stops("R8", exp_stops(7, early));
        tick; chk_stops("R8", exp_stops(8, early));
        tick; chk_stops("R8", exp_stops(0, early));
    endtask

    initial begin
        int unused_seed;
        unused_seed  = $urandom(32'h5eed);
        rst_n        = 1'b0;
        pd_n         = 1'b1;
        pci_stop_n   = 1'b1;
        pll_lock     = 1'b1;
        ref_stop_ack = 1'b0;
        repeat (3) tick;
        rst_n = 1'b1;
        tick;
        chk_stops("R1", 7'b0);
        chk_bit("R1", "osc_en", osc_en, 1'b1);
        chk_bit("R1", "pll_en", pll_en, 1'b1);
        chk_bit("R1", "bias", cpu_bias2x, 1'b0);

        // One-cycle glitch on the request pin must be ignored.
        pd_n = 1'b0;
        tick;
        pd_n = 1'b1;
        repeat (4) tick;
        chk_stops("R2", 7'b0);
        chk_bit("R2", "osc_en", osc_en, 1'b1);

        power_cycle(1'b1, 0, 0, 2, 1'b0);
        power_cycle(1'b0, 3, 5, 0, 1'b0);
        power_cycle(1'b1, 2, 1, 0, 1'b1);
        power_cycle(1'b0, 0, 0, 0, 1'b1);

        for (int k = 0; k < 8; k++) begin
            power_cycle(1'($urandom_range(1, 0)), int'($urandom_range(6, 0)),
                        int'($urandom_range(9, 0)), int'($urandom_range(5, 0)),
                        1'($urandom_range(1, 0)));
            repeat (int'($urandom_range(4, 0))) tick;
        end

        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #(4 * 150000);
        if (!finished) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog expired at %0t", $time);
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule